// File: doc/BRIEF.md
# Split/Cascade 16-bit Timer-Counter

This block is a 16-bit timer/counter made of two 8-bit byte counters, a low byte and a high byte. A two-stage prescaler drives it. The first stage is a fixed 2-bit divider. The second stage is an 8-bit divider whose terminal value is programmable. A 2-bit mode input chooses how the two bytes are clocked and whether they act as one count or two. The choices are two independent prescaled 8-bit timers, a prescaled low-byte timer with a high-byte event counter, one prescaled 16-bit timer, or one 16-bit counter of external events.

Each count has a match register. On a tick where the count already equals its match value, the count returns to zero and a one-cycle interrupt pulse is raised. The external event input first passes through a two-flop synchronizer. It is then counted on its rising edge. A small run/hold state machine gates all activity, and while it is in the hold state the counts and the prescaler phase are frozen.

The state machine has two states, ST_HOLD and ST_RUN. The transition HOLD_TO_RUN is taken on a clock edge where `run_en` is 1. The transition RUN_TO_HOLD is taken on an edge where `run_en` is 0. Reset forces ST_HOLD.

Top module: `split_timer16`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), both counts read 0, both interrupt outputs are 0 and the run state is ST_HOLD.
- R2: While running, the prescaler emits one tick on every 4*(P+1)-th running edge, where P is `psc_reload`. The first tick falls on the 4*(P+1)-th running edge after reset.
- R3: With `mode_i` = 0, the low and high bytes are independent 8-bit timers. Both advance on prescaler ticks, and each reloads at its own match value.
- R4: With `mode_i` = 1, the low byte advances on prescaler ticks and the high byte advances on synchronized rising edges of `event_in`.
- R5: With `mode_i` = 2, the bytes form one 16-bit timer {cnt_hi,cnt_lo} that advances on prescaler ticks. The low byte carries into the high byte when it passes 255. The match compares the full value against {match_hi,match_lo}.
- R6: With `mode_i` = 3, the bytes form one 16-bit counter of `event_in` rising edges, with the same carry and 16-bit match as R5.
- R7: On a tick where a count equals its match value, that count becomes 0 and its interrupt output is 1 for exactly one cycle. In modes 2 and 3, a 16-bit match pulses `irq_hi` only, and `irq_lo` stays 0.
- R8: An `event_in` pulse that stays high for at least 2 cycles and low for at least 2 cycles is counted exactly once, however long it stays high. In modes 0 and 2, events have no effect on either count.
- R9: `run_en` is registered, so running edges begin one edge after it is seen high. Clearing it freezes both counts and the prescaler phase, and counting resumes from the frozen phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run request; low holds everything |
| mode_i | input | 2 | 0 split timers, 1 timer+event, 2 16-bit timer, 3 16-bit event counter |
| psc_reload | input | 8 | Terminal value P of the programmable prescaler stage |
| match_lo | input | 8 | Low-byte match value (low half of the 16-bit match) |
| match_hi | input | 8 | High-byte match value (high half of the 16-bit match) |
| event_in | input | 1 | Asynchronous external event input |
| cnt_lo | output | 8 | Low byte count |
| cnt_hi | output | 8 | High byte count |
| irq_lo | output | 1 | Low-byte match pulse |
| irq_hi | output | 1 | High-byte or 16-bit match pulse |

## Verification
A count advances on the edge that follows its tick condition. A prescaled tick lands on the 4*(P+1)-th running edge. A rising edge on `event_in` placed before edge k is counted at edge k+2, after two synchronizer flops and one edge flop. An interrupt pulse appears on the same edge as its reload and drops one edge later. Raising or clearing `run_en` takes effect one edge after it is seen, so a run window of N edges gives exactly N running edges. The bench drives inputs on falling edges and samples outputs on falling edges. It reads final counts one edge after stop, when they are frozen, and reads them again after a hold interval. It counts interrupt pulses on every falling edge of the window, and a directed test pins down the exact edge of the first prescaled increment.

// File: rtl/split_timer16_pkg.sv
package split_timer16_pkg;
    typedef enum logic [1:0] {
        MODE_SPLIT   = 2'd0,
        MODE_MIXED   = 2'd1,
        MODE_CAS_TMR = 2'd2,
        MODE_CAS_EVT = 2'd3
    } tmr_mode_e;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam int NUM_LANES = 2;
endpackage

// File: rtl/split_timer16_prescale.sv
module split_timer16_prescale #(
    parameter int FIX_W = 2,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] reload,
    output logic             tick_o
);
    localparam logic [FIX_W-1:0] FIX_LAST = {FIX_W{1'b1}};

    logic [FIX_W-1:0] fix_q;
    logic [PSC_W-1:0] prog_q;
    logic             fix_tick;
    logic             prog_end;

    assign fix_tick = en && (fix_q == FIX_LAST);
    assign prog_end = (prog_q == reload);
    assign tick_o   = fix_tick && prog_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fix_q  <= '0;
            prog_q <= '0;
        end else if (en) begin
            fix_q <= fix_q + 1'b1;
            if (fix_tick) begin
                prog_q <= prog_end ? '0 : prog_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/split_timer16_evsync.sv
module split_timer16_evsync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic meta_q;
    logic sync_q;
    logic last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise_o = sync_q && !last_q;
endmodule

// File: rtl/split_timer16_bytecnt.sv
module split_timer16_bytecnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wrap,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/split_timer16.sv
module split_timer16
    import split_timer16_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PSC_W  = 8,
    parameter int FIX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [1:0]        mode_i,
    input  logic [PSC_W-1:0]  psc_reload,
    input  logic [BYTE_W-1:0] match_lo,
    input  logic [BYTE_W-1:0] match_hi,
    input  logic              event_in,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam logic [BYTE_W-1:0] BYTE_MAX = {BYTE_W{1'b1}};

    run_state_e state_q, state_d;
    tmr_mode_e  mode;
    logic       active;
    logic       psc_tick;
    logic       ev_rise;
    logic       ev_tick;

    logic [NUM_LANES-1:0] lane_inc;
    logic [NUM_LANES-1:0] lane_wrap;
    logic [BYTE_W-1:0]    lane_cnt [NUM_LANES];

    logic lo_hit, hi_hit, full_hit, step16;
    logic irq_lo_d, irq_hi_d;

    assign mode   = tmr_mode_e'(mode_i);
    assign active = (state_q == ST_RUN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // transitions HOLD_TO_RUN / RUN_TO_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (run_en)  state_d = ST_RUN;
            ST_RUN:  if (!run_en) state_d = ST_HOLD;
        endcase
    end

    split_timer16_prescale #(.FIX_W(FIX_W), .PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (active),
        .reload (psc_reload),
        .tick_o (psc_tick)
    );

    split_timer16_evsync u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (event_in),
        .rise_o  (ev_rise)
    );

    assign ev_tick  = ev_rise && active;
    assign lo_hit   = (lane_cnt[0] == match_lo);
    assign hi_hit   = (lane_cnt[1] == match_hi);
    assign full_hit = lo_hit && hi_hit;
    assign step16   = (mode == MODE_CAS_TMR) ? psc_tick : ev_tick;

    // step routing per mode
    always_comb begin
        lane_inc  = '0;
        lane_wrap = '0;
        irq_lo_d  = 1'b0;
        irq_hi_d  = 1'b0;
        unique case (mode)
            MODE_SPLIT, MODE_MIXED: begin
                lane_wrap[0] = psc_tick && lo_hit;
                lane_inc[0]  = psc_tick && !lo_hit;
                if (mode == MODE_SPLIT) begin
                    lane_wrap[1] = psc_tick && hi_hit;
                    lane_inc[1]  = psc_tick && !hi_hit;
                end else begin
                    lane_wrap[1] = ev_tick && hi_hit;
                    lane_inc[1]  = ev_tick && !hi_hit;
                end
                irq_lo_d = lane_wrap[0];
                irq_hi_d = lane_wrap[1];
            end
            MODE_CAS_TMR, MODE_CAS_EVT: begin
                lane_wrap = {NUM_LANES{step16 && full_hit}};
                lane_inc[0] = step16 && !full_hit;
                lane_inc[1] = step16 && !full_hit && (lane_cnt[0] == BYTE_MAX);
                irq_hi_d = step16 && full_hit;
            end
        endcase
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        split_timer16_bytecnt #(.W(BYTE_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (lane_inc[g]),
            .wrap  (lane_wrap[g]),
            .cnt   (lane_cnt[g])
        );
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
        end else begin
            irq_lo <= irq_lo_d;
            irq_hi <= irq_hi_d;
        end
    end

    assign cnt_lo = lane_cnt[0];
    assign cnt_hi = lane_cnt[1];
endmodule

// File: rtl/split_timer16_props.sv
module split_timer16_props #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [1:0]        mode_i,
    input logic [BYTE_W-1:0] cnt_lo,
    input logic [BYTE_W-1:0] cnt_hi,
    input logic              irq_lo,
    input logic              irq_hi
);
    assert_irq_lo_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |=> !irq_lo);

    assert_irq_hi_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |=> !irq_hi);

    assert_irq_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo || irq_hi) |-> ((!irq_lo || cnt_lo == '0) && (!irq_hi || cnt_hi == '0)));

    assert_cascade_lo_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_i[1]) |-> !irq_lo);

    assert_lo_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_lo) |-> (cnt_lo == $past(cnt_lo) + 1'b1 || cnt_lo == '0));

    assert_hold_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_en, 2) |-> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

bind split_timer16 split_timer16_props #(.BYTE_W(BYTE_W)) u_props (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .mode_i (mode_i),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .irq_lo (irq_lo),
    .irq_hi (irq_hi)
);

// File: tb/split_timer16_tb_top.sv
module split_timer16_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [7:0] psc_reload = 8'd0;
    logic [7:0] match_lo = 8'd0;
    logic [7:0] match_hi = 8'd0;
    logic       event_in = 1'b0;
    logic [7:0] cnt_lo, cnt_hi;
    logic       irq_lo, irq_hi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    split_timer16 dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_i(mode_i),
        .psc_reload(psc_reload), .match_lo(match_lo), .match_hi(match_hi),
        .event_in(event_in), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  psc;
        logic [7:0]  mlo;
        logic [7:0]  mhi;
        logic [15:0] ncyc;
        logic [7:0]  nev;
        logic [7:0]  wid;
        logic [7:0]  exp_lo;
        logic [7:0]  exp_hi;
        logic [7:0]  exp_ilo;
        logic [7:0]  exp_ihi;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd0, 8'd2,   8'd5,   16'd40,   8'd0,  8'd0,  8'd1,    8'd4, 8'd3, 8'd1}, // R3
        '{2'd0, 8'd1, 8'd255, 8'd3,   16'd80,   8'd0,  8'd0,  8'd10,   8'd2, 8'd0, 8'd2}, // R2 R3
        '{2'd2, 8'd0, 8'd5,   8'd1,   16'd1200, 8'd0,  8'd0,  8'd38,   8'd0, 8'd0, 8'd1}, // R5 match
        '{2'd2, 8'd0, 8'd255, 8'd255, 16'd2800, 8'd0,  8'd0,  8'hBC,   8'd2, 8'd0, 8'd0}, // R5 carry
        '{2'd2, 8'd2, 8'd3,   8'd0,   16'd108,  8'd0,  8'd0,  8'd1,    8'd0, 8'd0, 8'd2}, // R5 R7
        '{2'd0, 8'd4, 8'd0,   8'd255, 16'd159,  8'd0,  8'd0,  8'd0,    8'd7, 8'd7, 8'd0}, // R7 match 0
        '{2'd1, 8'd0, 8'd3,   8'd255, 16'd40,   8'd5,  8'd3,  8'd2,    8'd5, 8'd2, 8'd0}, // R4
        '{2'd3, 8'd0, 8'd255, 8'd255, 16'd260,  8'd12, 8'd10, 8'd12,   8'd0, 8'd0, 8'd0}, // R6 R8 long
        '{2'd3, 8'd0, 8'd4,   8'd0,   16'd60,   8'd7,  8'd2,  8'd2,    8'd0, 8'd0, 8'd1}, // R6 R8 min width
        '{2'd0, 8'd0, 8'd2,   8'd5,   16'd40,   8'd5,  8'd3,  8'd1,    8'd4, 8'd3, 8'd1}, // R8 ignored mode 0
        '{2'd2, 8'd0, 8'd255, 8'd255, 16'd40,   8'd5,  8'd3,  8'd10,   8'd0, 8'd0, 8'd0}  // R8 ignored mode 2
    };

    int  seen_ilo = 0, seen_ihi = 0, dbl = 0;
    bit  prev_ilo = 1'b0, prev_ihi = 1'b0;

    always @(negedge clk) begin
        if (irq_lo) seen_ilo++;
        if (irq_hi) seen_ihi++;
        if ((irq_lo && prev_ilo) || (irq_hi && prev_ihi)) dbl++;
        prev_ilo = irq_lo;
        prev_ihi = irq_hi;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic setup(input logic [1:0] m, input logic [7:0] p,
                         input logic [7:0] ml, input logic [7:0] mh);
        @(negedge clk);
        rst_n = 1'b0; run_en = 1'b0; event_in = 1'b0;
        mode_i = m; psc_reload = p; match_lo = ml; match_hi = mh;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        seen_ilo = 0; seen_ihi = 0; dbl = 0;
    endtask

    // gives exactly n running edges, then returns on the falling edge after stop
    task automatic run_window(input int n, input int ne, input int w);
        run_en = 1'b1;
        fork
            repeat (n) @(posedge clk);
            for (int e = 0; e < ne; e++) begin
                event_in = 1'b1;
                repeat (w) @(negedge clk);
                event_in = 1'b0;
                repeat (w) @(negedge clk);
            end
        join
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 cnt_lo", cnt_lo, 0);
        chk("R1 cnt_hi", cnt_hi, 0);
        chk("R1 irq", {irq_lo, irq_hi}, 0);

        for (int i = 0; i < NV; i++) begin
            setup(VECS[i].mode, VECS[i].psc, VECS[i].mlo, VECS[i].mhi);
            run_window(int'(VECS[i].ncyc), int'(VECS[i].nev), int'(VECS[i].wid));
            chk($sformatf("R3-6 vec%0d cnt_lo", i), cnt_lo, VECS[i].exp_lo);
            chk($sformatf("R3-6 vec%0d cnt_hi", i), cnt_hi, VECS[i].exp_hi);
            chk($sformatf("R7 vec%0d irq_lo pulses", i), seen_ilo, VECS[i].exp_ilo);
            chk($sformatf("R7 vec%0d irq_hi pulses", i), seen_ihi, VECS[i].exp_ihi);
            chk($sformatf("R7 vec%0d single-cycle", i), dbl, 0);
            repeat (20) @(negedge clk);
            chk($sformatf("R9 vec%0d held", i), {cnt_hi, cnt_lo},
                {VECS[i].exp_hi, VECS[i].exp_lo});
        end

        // R2 R9: first prescaled increment lands on the 5th edge after run_en is raised
        setup(2'd0, 8'd0, 8'd255, 8'd255);
        run_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 before first tick", cnt_lo, 0);
        @(negedge clk);
        chk("R2 first tick", cnt_lo, 1);
        run_en = 1'b0;
        repeat (3) @(negedge clk);

        // R9: prescaler phase kept across a hold
        setup(2'd0, 8'd0, 8'd255, 8'd255);
        run_window(6, 0, 0);
        chk("R9 after 6 running edges", cnt_lo, 1);
        repeat (10) @(negedge clk);
        run_window(2, 0, 0);
        chk("R9 resumed phase", cnt_lo, 2);

        // R1: reset mid-count clears everything
        setup(2'd0, 8'd0, 8'd255, 8'd255);
        run_window(40, 0, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset clears count", {cnt_hi, cnt_lo}, 0);

        finish_run();
    end
endmodule